// File: doc/BRIEF.md
# Raster Interrupt and Status Controller

This block holds the interrupt and beam-timing status registers that sit beside a game console's main CPU. A video timing generator feeds it the 9-bit horizontal and vertical beam counts and event strobes: start of line, start of horizontal blanking and start of vertical blanking. From these the block raises a level timer IRQ when the beam reaches a programmed position. It also raises a delayed one-cycle NMI at the start of vertical blanking and pulses a counter-latch output so the video side can capture its beam counters.

The CPU reaches the block through a byte-wide register port. The port has address, read strobe, write strobe and write data. Read data is combinational from the current state. A read or write is taken on the clock edge at which its strobe is high. The port has no back-pressure: every strobe is accepted in its own cycle, and there is no ready signal. Status bits that the block does not own are filled from an open-bus byte supplied by the surrounding chip. Flags clear as a side effect of being read. A general-purpose output port echoes its last written value, and a rising edge on its bit 7 requests a counter latch.

Register addresses: 0x0 control (write only; bit 7 NMI enable, bit 5 vertical timer enable, bit 4 horizontal timer enable, bit 0 automatic controller read enable). 0x1 output port write. 0x2/0x3 horizontal compare low/high. 0x4/0x5 vertical compare low/high, where the high byte uses bit 0 only. 0x8 NMI flag. 0x9 timer flag. 0xA blank status. 0xB output port readback.

Top module: `rasirq_ctrl`

## Requirements
- R1: After reset, irq_o, nmi_o and latch_o are 0, io_port is 0xFF, autoread_en is 0, all flags and status bits are 0, and both compare values are 0x1FF.
- R2: With control bit 5 set and bit 4 clear, a line_start strobe whose v_count equals the vertical compare fires the timer: from the next edge the timer flag is set and irq_o is high. Non-matching lines do not fire it.
- R3: With control bit 4 set, the timer fires on the edge where h_count first equals the horizontal compare. If bit 5 is also set, it fires only while v_count equals the vertical compare.
- R4: latch_o is high for exactly one cycle after each timer fire.
- R5: Reading address 0x9 returns {timer flag, open_bus[6:0]}. A read or any write to 0x9 clears the flag and drops irq_o at that edge. A timer fire in the same cycle takes priority.
- R6: A control write with bits 5 and 4 both 0 clears the timer flag and drops irq_o.
- R7: vblank_start sets the vblank status bit, the busy bit and the NMI flag.
- R8: If control bit 7 is set when vblank_start is sampled, nmi_o pulses for one cycle, starting at the 12th edge after the sampling edge. No pulse occurs if bit 7 is clear. No further pulse occurs until the NMI flag has been cleared.
- R9: Reading address 0x8 returns {NMI flag, open_bus[6:4], 4'h2} and clears the flag.
- R10: hblank_start sets the hblank status bit and line_start clears it. A line_start with v_count equal to 0 clears the vblank bit and the NMI flag.
- R11: Reading address 0xA returns {vblank, hblank, open_bus[5:1], busy}. An autoread_done strobe clears busy.
- R12: A write to 0x1 sets io_port, and reading 0xB returns it. latch_o pulses one cycle after a write that changes io_port bit 7 from 0 to 1, and not on other writes.
- R13: Reads of any other address return open_bus unchanged. autoread_en follows control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| open_bus | input | 8 | Open-bus byte for unowned bits |
| h_count | input | 9 | Horizontal beam count |
| v_count | input | 9 | Vertical beam count |
| hblank_start | input | 1 | Start-of-hblank strobe |
| line_start | input | 1 | Start-of-line strobe |
| vblank_start | input | 1 | Start-of-vblank strobe |
| autoread_done | input | 1 | Controller auto-read finished strobe |
| irq_o | output | 1 | Timer IRQ level |
| nmi_o | output | 1 | One-cycle NMI pulse |
| latch_o | output | 1 | Beam counter latch pulse |
| io_port | output | 8 | General-purpose output port |
| autoread_en | output | 1 | Automatic controller read enable |

## Verification
The hardest situation to reach is the NMI re-arm guard. It needs two vertical-blank starts with no flag read between them, followed by a third start after a read. Only then does the bench show that the second start stays silent and the third pulses again. The stimulus steps through these three starts in order and counts edges from each sampled strobe across a window wider than the delay. The horizontal timer has a similar problem: it must be gated by a mismatching line and then a matching one. The bench sweeps h_count through a random compare value on both kinds of line.

// File: rtl/rasirq_pkg.sv
package rasirq_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL       = 4'h0;
  localparam logic [ADDR_W-1:0] A_PORT_WR    = 4'h1;
  localparam logic [ADDR_W-1:0] A_HCMP_LO    = 4'h2;
  localparam logic [ADDR_W-1:0] A_HCMP_HI    = 4'h3;
  localparam logic [ADDR_W-1:0] A_VCMP_LO    = 4'h4;
  localparam logic [ADDR_W-1:0] A_VCMP_HI    = 4'h5;
  localparam logic [ADDR_W-1:0] A_NMI_FLAG   = 4'h8;
  localparam logic [ADDR_W-1:0] A_TIMER_FLAG = 4'h9;
  localparam logic [ADDR_W-1:0] A_STATUS     = 4'hA;
  localparam logic [ADDR_W-1:0] A_PORT_RD    = 4'hB;

  localparam int B_NMI_EN = 7;
  localparam int B_V_EN   = 5;
  localparam int B_H_EN   = 4;
  localparam int B_AUTORD = 0;

  typedef struct packed {
    logic nmi_en;
    logic v_en;
    logic h_en;
    logic auto_rd;
  } ctrl_t;
endpackage

// File: rtl/rasirq_cmpreg.sv
module rasirq_cmpreg #(
  parameter int W = 9,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [7:0]   wdata,
  output logic [W-1:0] val
);
  localparam int HI_W = W - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= RESET_VAL;
    end else begin
      if (wr_lo) val[7:0] <= wdata;
      if (wr_hi) val[W-1:8] <= wdata[HI_W-1:0];
    end
  end

  // R3
  cmp_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> val[7:0] == $past(wdata));
endmodule

// File: rtl/rasirq_timer.sv
module rasirq_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_en,
  input  logic             v_en,
  input  logic [CNT_W-1:0] h_count,
  input  logic [CNT_W-1:0] v_count,
  input  logic [CNT_W-1:0] hcmp,
  input  logic [CNT_W-1:0] vcmp,
  input  logic             line_start,
  output logic             fire
);
  logic v_hit, h_cond, h_cond_q, fire_h, fire_v;

  assign v_hit  = (v_count == vcmp);
  assign h_cond = h_en && (h_count == hcmp) && (!v_en || v_hit);
  assign fire_h = h_cond && !h_cond_q;
  assign fire_v = v_en && !h_en && line_start && v_hit;
  assign fire   = fire_h || fire_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_cond_q <= 1'b0;
    else        h_cond_q <= h_cond;
  end

  // R2
  timer_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (h_en || v_en));
  // R3
  h_fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && h_en) |=> !(fire && $stable(h_count) && $stable(v_count) && h_en));
endmodule

// File: rtl/rasirq_nmi.sv
module rasirq_nmi #(
  parameter int NMI_DELAY = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_start,
  input  logic vblank_end,
  input  logic flag_rd,
  input  logic nmi_en,
  output logic nmi_flag,
  output logic nmi_o
);
  localparam int DLY_W = $clog2(NMI_DELAY + 1);

  logic             armed_q;
  logic [DLY_W-1:0] cnt_q;
  logic             start;

  assign start = vblank_start && nmi_en && !armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_flag <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      nmi_o    <= 1'b0;
    end else begin
      if (vblank_start)               nmi_flag <= 1'b1;
      else if (flag_rd || vblank_end) nmi_flag <= 1'b0;

      if (start)                      armed_q <= 1'b1;
      else if (flag_rd || vblank_end) armed_q <= 1'b0;

      if (start)              cnt_q <= DLY_W'(NMI_DELAY);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;

      nmi_o <= (cnt_q == DLY_W'(1)) && !start;
    end
  end

  // R8
  nmi_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |=> !nmi_o);
  // R7
  nmi_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_flag) |-> $past(vblank_start));
  // R9
  nmi_flag_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !vblank_start) |=> !nmi_flag);
endmodule

// File: rtl/rasirq_ctrl.sv
module rasirq_ctrl
  import rasirq_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int NMI_DELAY = 12,
  parameter logic [3:0] VERSION = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        open_bus,
  input  logic [CNT_W-1:0]  h_count,
  input  logic [CNT_W-1:0]  v_count,
  input  logic              hblank_start,
  input  logic              line_start,
  input  logic              vblank_start,
  input  logic              autoread_done,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              latch_o,
  output logic [7:0]        io_port,
  output logic              autoread_en
);
  localparam int NCMP = 2;

  ctrl_t            ctrl_q;
  logic             tflag_q, hblank_q, vblank_q, busy_q;
  logic             timer_fire, tflag_clr, port_rise, vblank_end;
  logic             nmi_flag, nmi_rd;
  logic             ctrl_wr, port_wr;
  logic [CNT_W-1:0] cmp_val [NCMP];

  assign ctrl_wr    = bus_wr && (bus_addr == A_CTRL);
  assign port_wr    = bus_wr && (bus_addr == A_PORT_WR);
  assign port_rise  = port_wr && !io_port[7] && bus_wdata[7];
  assign vblank_end = line_start && (v_count == '0);
  assign nmi_rd     = bus_rd && (bus_addr == A_NMI_FLAG);
  assign tflag_clr  = ((bus_rd || bus_wr) && (bus_addr == A_TIMER_FLAG)) ||
                      (ctrl_wr && (bus_wdata[B_V_EN:B_H_EN] == 2'b00));

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
    localparam logic [ADDR_W-1:0] LO_A = (gi == 0) ? A_HCMP_LO : A_VCMP_LO;
    localparam logic [ADDR_W-1:0] HI_A = (gi == 0) ? A_HCMP_HI : A_VCMP_HI;
    rasirq_cmpreg #(.W(CNT_W), .RESET_VAL('1)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (bus_wr && (bus_addr == LO_A)),
      .wr_hi (bus_wr && (bus_addr == HI_A)),
      .wdata (bus_wdata),
      .val   (cmp_val[gi])
    );
  end

  rasirq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_en       (ctrl_q.h_en),
    .v_en       (ctrl_q.v_en),
    .h_count    (h_count),
    .v_count    (v_count),
    .hcmp       (cmp_val[0]),
    .vcmp       (cmp_val[1]),
    .line_start (line_start),
    .fire       (timer_fire)
  );

  rasirq_nmi #(.NMI_DELAY(NMI_DELAY)) u_nmi (
    .clk          (clk),
    .rst_n        (rst_n),
    .vblank_start (vblank_start),
    .vblank_end   (vblank_end),
    .flag_rd      (nmi_rd),
    .nmi_en       (ctrl_q.nmi_en),
    .nmi_flag     (nmi_flag),
    .nmi_o        (nmi_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      tflag_q  <= 1'b0;
      hblank_q <= 1'b0;
      vblank_q <= 1'b0;
      busy_q   <= 1'b0;
      io_port  <= 8'hFF;
      latch_o  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.nmi_en  <= bus_wdata[B_NMI_EN];
        ctrl_q.v_en    <= bus_wdata[B_V_EN];
        ctrl_q.h_en    <= bus_wdata[B_H_EN];
        ctrl_q.auto_rd <= bus_wdata[B_AUTORD];
      end
      if (timer_fire)     tflag_q <= 1'b1;
      else if (tflag_clr) tflag_q <= 1'b0;

      if (hblank_start)    hblank_q <= 1'b1;
      else if (line_start) hblank_q <= 1'b0;

      if (vblank_start)    vblank_q <= 1'b1;
      else if (vblank_end) vblank_q <= 1'b0;

      if (vblank_start)       busy_q <= 1'b1;
      else if (autoread_done) busy_q <= 1'b0;

      if (port_wr) io_port <= bus_wdata;
      latch_o <= timer_fire || port_rise;
    end
  end

  assign irq_o       = tflag_q;
  assign autoread_en = ctrl_q.auto_rd;

  always_comb begin
    bus_rdata = open_bus;
    case (bus_addr)
      A_NMI_FLAG:   bus_rdata = {nmi_flag, open_bus[6:4], VERSION};
      A_TIMER_FLAG: bus_rdata = {tflag_q, open_bus[6:0]};
      A_STATUS:     bus_rdata = {vblank_q, hblank_q, open_bus[5:1], busy_q};
      A_PORT_RD:    bus_rdata = io_port;
      default:      ;
    endcase
  end

  // R5
  tflag_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_TIMER_FLAG && !timer_fire) |=> !irq_o);
  // R6
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[5:4] == 2'b00 && !timer_fire) |=> !irq_o);
  // R4
  irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> latch_o);
  // R12
  port_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> io_port == $past(bus_wdata));
  // R11
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (autoread_done && !vblank_start) |=> !busy_q);
endmodule

// File: tb/rasirq_ctrl_test.sv
module rasirq_ctrl_test;
  import rasirq_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = '0, bus_rdata, open_bus = '0, io_port;
  logic [8:0] h_count = '0, v_count = 9'd1;
  logic hblank_start = 0, line_start = 0, vblank_start = 0, autoread_done = 0;
  logic irq_o, nmi_o, latch_o, autoread_en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rasirq_ctrl uut (.*);

  function automatic logic [7:0] exp_tf(logic f, logic [7:0] ob); return {f, ob[6:0]}; endfunction
  function automatic logic [7:0] exp_nf(logic f, logic [7:0] ob); return {f, ob[6:4], 4'h2}; endfunction
  function automatic logic [7:0] exp_st(logic vb, logic hb, logic bz, logic [7:0] ob);
    return {vb, hb, ob[5:1], bz};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    open_bus = 8'($urandom); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic lstart(input logic [8:0] v);
    v_count = v; line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic vbs();
    vblank_start = 1;
    @(negedge clk); vblank_start = 0;
  endtask

  // counts NMI pulses over a window after a vblank_start; returns edge index of first pulse
  task automatic nmi_window(output int pulses, output int first);
    pulses = 0; first = -1;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (nmi_o) begin pulses++; if (first < 0) first = i; end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d, e;
    logic [8:0] v, h;
    int p, f;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(!irq_o && !nmi_o && !latch_o && !autoread_en, "R1 outputs", {irq_o,nmi_o,latch_o,autoread_en}, 0);
    check(io_port == 8'hFF, "R1 io_port", io_port, 8'hFF);
    rd(A_STATUS, d); e = exp_st(0, 0, 0, open_bus);
    check(d == e, "R1 status", d, e);
    rd(A_TIMER_FLAG, d); e = exp_tf(0, open_bus);
    check(d == e, "R1 timer flag", d, e);
    wr(A_CTRL, 8'h20);
    lstart(9'h1FF);
    check(irq_o == 1, "R1 vcmp reset 0x1FF", irq_o, 1);
    rd(A_TIMER_FLAG, d);

    // R13 open bus and autoread
    foreach (e[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [3:0] a;
      a = (k == 0) ? A_CTRL : (k == 1) ? 4'h6 : (k == 2) ? 4'hC : 4'hF;
      rd(a, d);
      check(d == open_bus, "R13 open bus", d, open_bus);
    end
    wr(A_CTRL, 8'h01);
    check(autoread_en == 1, "R13 autoread_en", autoread_en, 1);

    // R2 vertical timer, random lines
    for (int k = 0; k < 8; k++) begin
      v = 9'(1 + ($urandom % 300));
      wr(A_VCMP_LO, v[7:0]); wr(A_VCMP_HI, {7'b0, v[8]});
      wr(A_CTRL, 8'h20);
      h_count = 9'($urandom);
      lstart(v + 9'd1);
      check(irq_o == 0, "R2 mismatch line", irq_o, 0);
      lstart(v);
      check(irq_o == 1 && latch_o == 1, "R2/R4 fire", {irq_o, latch_o}, 3);
      @(negedge clk);
      check(latch_o == 0 && irq_o == 1, "R4 latch width", {irq_o, latch_o}, 2);
      rd(A_TIMER_FLAG, d); e = exp_tf(1, open_bus);
      check(d == e, "R5 flag read", d, e);
      check(irq_o == 0, "R5 read clears", irq_o, 0);
      rd(A_TIMER_FLAG, d); e = exp_tf(0, open_bus);
      check(d == e, "R5 flag after clear", d, e);
    end

    // R3 horizontal timer
    h = 9'(10 + ($urandom % 300));
    wr(A_HCMP_LO, h[7:0]); wr(A_HCMP_HI, {7'b0, h[8]});
    v_count = 9'd40;
    for (int i = 3; i >= 1; i--) begin h_count = h - 9'(i); @(negedge clk); end
    wr(A_CTRL, 8'h10);
    check(irq_o == 0, "R3 before match", irq_o, 0);
    h_count = h; @(negedge clk);
    check(irq_o == 1 && latch_o == 1, "R3/R4 h fire", {irq_o, latch_o}, 3);
    wr(A_TIMER_FLAG, 8'h00);
    check(irq_o == 0, "R5 write clears", irq_o, 0);
    @(negedge clk);
    check(irq_o == 0, "R3 no refire while held", irq_o, 0);
    wr(A_VCMP_LO, 8'd50); wr(A_VCMP_HI, 8'd0);
    wr(A_CTRL, 8'h30);
    v_count = 9'd49;
    for (int i = -2; i <= 2; i++) begin h_count = h + 9'(i); @(negedge clk); end
    check(irq_o == 0, "R3 gated by line", irq_o, 0);
    v_count = 9'd50;
    h_count = h - 9'd1; @(negedge clk);
    h_count = h; @(negedge clk);
    check(irq_o == 1, "R3 fire on matching line", irq_o, 1);
    wr(A_CTRL, 8'h80);
    check(irq_o == 0, "R6 ctrl clears", irq_o, 0);

    // R7/R8/R9 NMI
    vbs();
    nmi_window(p, f);
    check(p == 1 && f == 12, "R8 nmi timing", f, 12);
    rd(A_STATUS, d); e = exp_st(1, 0, 1, open_bus);
    check(d == e, "R7 status", d, e);
    vbs();
    nmi_window(p, f);
    check(p == 0, "R8 blocked rearm", p, 0);
    rd(A_NMI_FLAG, d); e = exp_nf(1, open_bus);
    check(d == e, "R9 nmi flag read", d, e);
    rd(A_NMI_FLAG, d); e = exp_nf(0, open_bus);
    check(d == e, "R9 cleared", d, e);
    vbs();
    nmi_window(p, f);
    check(p == 1 && f == 12, "R8 rearmed", f, 12);
    rd(A_NMI_FLAG, d);
    wr(A_CTRL, 8'h00);
    vbs();
    nmi_window(p, f);
    check(p == 0, "R8 disabled", p, 0);
    rd(A_NMI_FLAG, d); e = exp_nf(1, open_bus);
    check(d == e, "R7 flag set when disabled", d, e);

    // R11 busy, R10 hblank/vblank end
    autoread_done = 1; @(negedge clk); autoread_done = 0;
    hblank_start = 1; @(negedge clk); hblank_start = 0;
    rd(A_STATUS, d); e = exp_st(1, 1, 0, open_bus);
    check(d == e, "R10/R11 hblank set busy clear", d, e);
    vbs();
    lstart(9'd5);
    rd(A_STATUS, d); e = exp_st(1, 0, 1, open_bus);
    check(d == e, "R10 line start clears hblank", d, e);
    lstart(9'd0);
    rd(A_STATUS, d); e = exp_st(0, 0, 1, open_bus);
    check(d == e, "R10 vblank end", d, e);
    rd(A_NMI_FLAG, d); e = exp_nf(0, open_bus);
    check(d == e, "R10 nmi flag cleared", d, e);

    // R12 output port
    wr(A_PORT_WR, 8'h00);
    check(latch_o == 0, "R12 falling no latch", latch_o, 0);
    wr(A_PORT_WR, 8'h80);
    check(latch_o == 1, "R12 rising latch", latch_o, 1);
    wr(A_PORT_WR, 8'h81);
    check(latch_o == 0, "R12 held high no latch", latch_o, 0);
    for (int k = 0; k < 4; k++) begin
      e = 8'($urandom);
      wr(A_PORT_WR, e);
      rd(A_PORT_RD, d);
      check(d == e && io_port == e, "R12 readback", d, e);
    end

    summary();
  end
endmodule